// File: doc/BRIEF.md
# Speculative Reorder Buffer with In-Order Retirement

This block is a circular reorder buffer for a speculative out-of-order core. Issue logic claims one entry per instruction. It can do so only when a reservation station is also free. The index of the claimed entry is handed back as the instruction's destination tag. Functional units later broadcast their results on a shared result bus, tagged with that index. The buffer captures the value and marks the entry complete. While an entry waits to retire, issue logic can look it up by tag: it receives the value if the entry is complete, or the tag to wait on if it is not.

Entries leave strictly in program order, one per cycle, from the head of the buffer. An ALU entry retires by writing its destination register. A store keeps its address and data inside its entry and releases them to memory only when it retires. A branch whose result says it was mispredicted discards every younger entry when it reaches the head. A separate flush input discards the whole buffer.

Top module: `rob_core`

## Requirements
- R1: `alloc_ready_o` is high only when the buffer is not full, `rs_avail_i` is high and no flush happens in that cycle. An accepted claim (`alloc_valid_i` and `alloc_ready_o`) returns `alloc_tag_o`, the tail index. Successive claims receive consecutive tags modulo 8.
- R2: After reset the buffer is empty: `alloc_ready_o` is high when `rs_avail_i` is high, and nothing retires. After 8 claims without retirement, `alloc_ready_o` is low.
- R3: A result bus write (`cdb_valid_i`) to a busy entry stores the value, the store address and the mispredict bit, and marks the entry complete from the next cycle on.
- R4: A lookup by `lk_tag_i` of a complete entry gives `lk_ready_o`=1 and the stored value on `lk_value_o`. For an entry that is not complete it gives `lk_ready_o`=0, `lk_value_o`=0 and `lk_wait_tag_o` equal to the tag. Lookups read stored state only, not the result bus in the same cycle.
- R5: Only the head entry retires, and only once it is complete. At most one entry retires per cycle, always in claim order, even when younger entries complete first.
- R6: Kind codes on `alloc_kind_i`/`commit_kind_o` are 0 = ALU, 1 = store, 2 = branch. An ALU entry retires with `rf_we_o`=1, `rf_addr_o` = its destination register and `rf_data_o` = its value.
- R7: A store retires with `st_en_o`=1, `st_addr_o`/`st_data_o` taken from its result, and no register write. `st_en_o` stays low until the store is at the head.
- R8: A branch whose mispredict bit is 0 retires with no register write, no store and `flush_o`=0.
- R9: A branch whose mispredict bit is 1 retires with `flush_o`=1. Every younger entry is discarded, and the next claim receives the index that follows the branch.
- R10: `flush_i` discards all entries, including the head, and blocks retirement in that cycle. The next claim receives the index of the old head.
- R11: During a flush cycle, claims and result bus writes are ignored.
- R12: A claim and a retirement can both take place in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rs_avail_i | input | 1 | A reservation station is free |
| alloc_valid_i | input | 1 | Request to claim an entry |
| alloc_kind_i | input | 2 | Instruction kind (0 ALU, 1 store, 2 branch) |
| alloc_dst_i | input | 5 | Destination register |
| alloc_ready_o | output | 1 | Claim is accepted this cycle |
| alloc_tag_o | output | 3 | Tag given to the claimed entry |
| cdb_valid_i | input | 1 | Result bus valid |
| cdb_tag_i | input | 3 | Result bus tag |
| cdb_value_i | input | 32 | Result value or store data |
| cdb_addr_i | input | 32 | Store address |
| cdb_mispred_i | input | 1 | Branch was mispredicted |
| lk_tag_i | input | 3 | Operand lookup tag |
| lk_ready_o | output | 1 | Looked-up entry is complete |
| lk_value_o | output | 32 | Forwarded value (0 if not complete) |
| lk_wait_tag_o | output | 3 | Tag to wait on |
| commit_valid_o | output | 1 | Head entry retires this cycle |
| commit_kind_o | output | 2 | Kind of the retiring entry |
| rf_we_o | output | 1 | Register file write |
| rf_addr_o | output | 5 | Register written |
| rf_data_o | output | 32 | Data written |
| st_en_o | output | 1 | Store released to memory |
| st_addr_o | output | 32 | Store address |
| st_data_o | output | 32 | Store data |
| flush_i | input | 1 | Discard all entries |
| flush_o | output | 1 | Mispredicted branch retired; younger entries discarded |

## Verification
Retirement order is tested with results that arrive out of order. A mix of ALU, store and branch entries completes youngest-first, which separates true in-order retirement from retire-on-complete. It also shows that a completed store is held until it reaches the head. A full buffer whose entries complete in reverse order shows the full limit, tag wrap-around and back-to-back single retirements. Three further patterns are used:
- A mispredicted branch followed by already-complete younger entries, to show that those entries are discarded, not retired.
- An external flush together with a claim and a result write, to show that both are dropped.
- A claim in the same cycle as a retirement.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned REG_W  = 5;
  localparam int unsigned ADDR_W = 32;

  typedef enum logic [1:0] {
    KIND_ALU = 2'd0,
    KIND_ST  = 2'd1,
    KIND_BR  = 2'd2
  } kind_e;

  typedef struct packed {
    logic              busy;
    logic              ready;
    kind_e             kind;
    logic [REG_W-1:0]  dst;
    logic [XLEN-1:0]   value;
    logic [ADDR_W-1:0] addr;
    logic              mispred;
  } entry_t;
endpackage

// File: rtl/rob_slot.sv
module rob_slot
  import rob_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  kind_e             kind_i,
  input  logic [REG_W-1:0]  dst_i,
  input  logic              wr_i,
  input  logic [XLEN-1:0]   value_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mis_i,
  input  logic              free_i,
  input  logic              clr_i,
  output entry_t            entry_o
);
  entry_t entry_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_q <= '0;
    end else if (clr_i) begin
      entry_q.busy  <= 1'b0;
      entry_q.ready <= 1'b0;
    end else begin
      if (wr_i && entry_q.busy) begin
        entry_q.ready   <= 1'b1;
        entry_q.value   <= value_i;
        entry_q.addr    <= addr_i;
        entry_q.mispred <= mis_i;
      end
      if (free_i) begin
        entry_q.busy  <= 1'b0;
        entry_q.ready <= 1'b0;
      end
      if (alloc_i) begin
        entry_q.busy    <= 1'b1;
        entry_q.ready   <= 1'b0;
        entry_q.kind    <= kind_i;
        entry_q.dst     <= dst_i;
        entry_q.value   <= '0;
        entry_q.addr    <= '0;
        entry_q.mispred <= 1'b0;
      end
    end
  end

  assign entry_o = entry_q;

  p_ready_needs_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_q.ready |-> entry_q.busy);

  p_write_marks_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && entry_q.busy && !clr_i && !free_i && !alloc_i) |=> entry_q.ready);

  p_clear_drops_entry_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!entry_q.busy && !entry_q.ready));
endmodule

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TAG_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output logic [TAG_W-1:0] head_o,
  output logic [TAG_W-1:0] tail_o,
  output logic             full_o,
  output logic             empty_o
);
  // DEPTH must be a power of two; the extra top bit marks the wrap
  localparam int unsigned PW = TAG_W + 1;

  logic [PW-1:0] head_q, tail_q, head_d, tail_d;

  always_comb begin
    head_d = head_q + PW'(pop_i);
    tail_d = flush_i ? head_d : tail_q + PW'(push_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  assign head_o  = head_q[TAG_W-1:0];
  assign tail_o  = tail_q[TAG_W-1:0];
  assign empty_o = (head_q == tail_q);
  assign full_o  = (head_q[TAG_W-1:0] == tail_q[TAG_W-1:0]) &&
                   (head_q[TAG_W] != tail_q[TAG_W]);

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);

  p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);

  p_flush_empties_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TAG_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rs_avail_i,
  input  logic              alloc_valid_i,
  input  logic [1:0]        alloc_kind_i,
  input  logic [REG_W-1:0]  alloc_dst_i,
  output logic              alloc_ready_o,
  output logic [TAG_W-1:0]  alloc_tag_o,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [XLEN-1:0]   cdb_value_i,
  input  logic [ADDR_W-1:0] cdb_addr_i,
  input  logic              cdb_mispred_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  output logic              lk_ready_o,
  output logic [XLEN-1:0]   lk_value_o,
  output logic [TAG_W-1:0]  lk_wait_tag_o,
  output logic              commit_valid_o,
  output logic [1:0]        commit_kind_o,
  output logic              rf_we_o,
  output logic [REG_W-1:0]  rf_addr_o,
  output logic [XLEN-1:0]   rf_data_o,
  output logic              st_en_o,
  output logic [ADDR_W-1:0] st_addr_o,
  output logic [XLEN-1:0]   st_data_o,
  input  logic              flush_i,
  output logic              flush_o
);
  entry_t           slots [DEPTH];
  entry_t           head_e, lk_e;
  logic [TAG_W-1:0] head, tail;
  logic             full, empty;
  logic             alloc_fire, commit_fire, flush_any, cdb_take;

  rob_ptrs #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ptrs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (alloc_fire),
    .pop_i   (commit_fire),
    .flush_i (flush_any),
    .head_o  (head),
    .tail_o  (tail),
    .full_o  (full),
    .empty_o (empty)
  );

  assign head_e = slots[head];
  assign lk_e   = slots[lk_tag_i];

  // retire path
  assign commit_fire = head_e.busy && head_e.ready && !flush_i;
  assign flush_o     = commit_fire && (head_e.kind == KIND_BR) && head_e.mispred;
  assign flush_any   = flush_i || flush_o;

  // claim path
  assign alloc_ready_o = !full && rs_avail_i && !flush_any;
  assign alloc_fire    = alloc_valid_i && alloc_ready_o;
  assign alloc_tag_o   = tail;
  assign cdb_take      = cdb_valid_i && !flush_any;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    rob_slot u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .alloc_i (alloc_fire && (tail == TAG_W'(i))),
      .kind_i  (kind_e'(alloc_kind_i)),
      .dst_i   (alloc_dst_i),
      .wr_i    (cdb_take && (cdb_tag_i == TAG_W'(i))),
      .value_i (cdb_value_i),
      .addr_i  (cdb_addr_i),
      .mis_i   (cdb_mispred_i),
      .free_i  (commit_fire && (head == TAG_W'(i))),
      .clr_i   (flush_any),
      .entry_o (slots[i])
    );
  end

  // operand forwarding
  assign lk_ready_o    = lk_e.busy && lk_e.ready;
  assign lk_value_o    = lk_ready_o ? lk_e.value : '0;
  assign lk_wait_tag_o = lk_tag_i;

  assign commit_valid_o = commit_fire;
  assign commit_kind_o  = head_e.kind;
  assign rf_we_o        = commit_fire && (head_e.kind == KIND_ALU);
  assign rf_addr_o      = head_e.dst;
  assign rf_data_o      = head_e.value;
  assign st_en_o        = commit_fire && (head_e.kind == KIND_ST);
  assign st_addr_o      = head_e.addr;
  assign st_data_o      = head_e.value;

  p_retire_in_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_fire |=> (head == TAG_W'($past(head) + 1'b1)));

  p_claim_takes_slot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_fire |=> slots[$past(alloc_tag_o)].busy);

  p_flush_leaves_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (empty && !commit_fire));

  p_single_retire_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({rf_we_o, st_en_o}) <= 1);
endmodule

// File: tb/rob_core_tb_top.sv
`timescale 1ns/1ps
module rob_core_tb_top;
  import rob_pkg::*;
  localparam int DEPTH = 8;
  localparam int TW    = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rs_avail_i = 1'b1, alloc_valid_i = 1'b0;
  logic [1:0] alloc_kind_i = '0;
  logic [REG_W-1:0] alloc_dst_i = '0;
  logic alloc_ready_o;
  logic [TW-1:0] alloc_tag_o;
  logic cdb_valid_i = 1'b0;
  logic [TW-1:0] cdb_tag_i = '0;
  logic [XLEN-1:0] cdb_value_i = '0;
  logic [ADDR_W-1:0] cdb_addr_i = '0;
  logic cdb_mispred_i = 1'b0;
  logic [TW-1:0] lk_tag_i = '0;
  logic lk_ready_o;
  logic [XLEN-1:0] lk_value_o;
  logic [TW-1:0] lk_wait_tag_o;
  logic commit_valid_o;
  logic [1:0] commit_kind_o;
  logic rf_we_o, st_en_o, flush_o;
  logic [REG_W-1:0] rf_addr_o;
  logic [XLEN-1:0] rf_data_o, st_data_o;
  logic [ADDR_W-1:0] st_addr_o;
  logic flush_i = 1'b0;

  always #2 clk_i = ~clk_i;

  rob_core dut_i (.*);

  typedef struct {
    int tag; int kind; int dst;
    logic [31:0] val; logic [31:0] addr;
    bit mis; bit done;
  } item_t;
  item_t q[$];
  int exp_tail = 0;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string msg,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, msg, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk_i); #1; end
  endtask

  task automatic do_alloc(input int kind, input int dst, output int tag);
    item_t it;
    alloc_valid_i = 1'b1; alloc_kind_i = kind[1:0]; alloc_dst_i = dst[REG_W-1:0];
    @(negedge clk_i);
    chk(alloc_ready_o, "R1", "claim accepted", alloc_ready_o, 1);
    chk(alloc_tag_o == exp_tail[TW-1:0], "R1", "claim tag", alloc_tag_o, exp_tail);
    tag = alloc_tag_o;
    it = '{tag: tag, kind: kind, dst: dst, val: 0, addr: 0, mis: 0, done: 0};
    q.push_back(it);
    exp_tail = (exp_tail + 1) % DEPTH;
    @(posedge clk_i); #1;
    alloc_valid_i = 1'b0;
  endtask

  task automatic send(input int tag, input logic [31:0] val, input logic [31:0] addr,
                      input bit mis);
    cdb_valid_i = 1'b1; cdb_tag_i = tag[TW-1:0]; cdb_value_i = val;
    cdb_addr_i = addr; cdb_mispred_i = mis;
    @(posedge clk_i); #1;
    cdb_valid_i = 1'b0; cdb_mispred_i = 1'b0;
    foreach (q[i]) if (q[i].tag == tag) begin
      q[i].val = val; q[i].addr = addr; q[i].mis = mis; q[i].done = 1;
    end
  endtask

  task automatic look(input int tag, output bit rdy, output logic [31:0] v,
                      output logic [TW-1:0] wt);
    lk_tag_i = tag[TW-1:0];
    #0.5;
    rdy = lk_ready_o; v = lk_value_o; wt = lk_wait_tag_o;
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      if (commit_valid_o) begin
        if (q.size() == 0) begin
          chk(0, "R5", "retire with nothing pending", 1, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          chk(it.done, "R5", "retire before result", 0, 1);
          chk(commit_kind_o == it.kind[1:0], "R5", "retire order kind", commit_kind_o, it.kind);
          if (it.kind == 0) begin
            chk(rf_we_o && !st_en_o, "R6", "alu reg write", rf_we_o, 1);
            chk(rf_addr_o == it.dst[REG_W-1:0], "R6", "alu dst", rf_addr_o, it.dst);
            chk(rf_data_o == it.val, "R6", "alu data", rf_data_o, it.val);
          end else if (it.kind == 1) begin
            chk(st_en_o && !rf_we_o, "R7", "store release", st_en_o, 1);
            chk(st_addr_o == it.addr, "R7", "store addr", st_addr_o, it.addr);
            chk(st_data_o == it.val, "R7", "store data", st_data_o, it.val);
          end else begin
            chk(!rf_we_o && !st_en_o, "R8", "branch no side effect", {rf_we_o, st_en_o}, 0);
            chk(flush_o == it.mis, "R9", "branch flush", flush_o, it.mis);
            if (it.mis) begin
              q.delete();
              exp_tail = (it.tag + 1) % DEPTH;
            end
          end
        end
      end else if (!flush_i && q.size() > 0 && q[0].done) begin
        chk(0, "R5", "complete head not retired", 0, 1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int t[8];
    int tb_, tx, ty, tp, tq, ta, tbb, dummy;
    bit rdy; logic [31:0] v; logic [TW-1:0] wt;

    tick(3);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(alloc_ready_o, "R2", "empty after reset", alloc_ready_o, 1);
    chk(!commit_valid_o, "R2", "no retire after reset", commit_valid_o, 0);
    @(posedge clk_i); #1;
    rs_avail_i = 1'b0; #0.5;
    chk(!alloc_ready_o, "R1", "no station blocks claim", alloc_ready_o, 0);
    rs_avail_i = 1'b1;

    // out-of-order completion, in-order retirement
    do_alloc(0, 3, t[0]);
    do_alloc(1, 0, t[1]);
    do_alloc(2, 0, t[2]);
    do_alloc(0, 7, t[3]);
    send(t[3], 32'h33, 0, 0);
    look(t[3], rdy, v, wt);
    chk(rdy && v == 32'h33, "R4", "lookup complete value", v, 32'h33);
    chk(rdy, "R3", "result marks ready", rdy, 1);
    look(t[0], rdy, v, wt);
    chk(!rdy && v == 0, "R4", "lookup pending not ready", rdy, 0);
    chk(wt == t[0][TW-1:0], "R4", "wait tag", wt, t[0]);
    send(t[1], 32'hAB, 32'h100, 0);
    @(negedge clk_i);
    chk(!commit_valid_o && !st_en_o, "R7", "store held behind head", st_en_o, 0);
    @(posedge clk_i); #1;
    send(t[0], 32'h11, 0, 0);
    tick(3);
    send(t[2], 0, 0, 0);
    tick(3);
    chk(q.size() == 0, "R5", "all retired", q.size(), 0);

    // fill, wrap, reverse completion
    for (int i = 0; i < 8; i++) do_alloc(0, i + 1, t[i]);
    alloc_valid_i = 1'b1; #0.5;
    chk(!alloc_ready_o, "R2", "full blocks claim", alloc_ready_o, 0);
    alloc_valid_i = 1'b0;
    for (int i = 7; i >= 0; i--) send(t[i], 32'h500 + i, 0, 0);
    tick(10);
    chk(q.size() == 0, "R5", "full drain", q.size(), 0);

    // claim and retire together
    do_alloc(0, 9, ta);
    send(ta, 32'hCAFE, 0, 0);
    alloc_valid_i = 1'b1; alloc_kind_i = 2'd0; alloc_dst_i = 5'd10;
    @(negedge clk_i);
    chk(alloc_ready_o && commit_valid_o, "R12", "claim with retire",
        {alloc_ready_o, commit_valid_o}, 3);
    chk(alloc_tag_o == exp_tail[TW-1:0], "R12", "tag", alloc_tag_o, exp_tail);
    tbb = alloc_tag_o;
    q.push_back('{tag: tbb, kind: 0, dst: 10, val: 0, addr: 0, mis: 0, done: 0});
    exp_tail = (exp_tail + 1) % DEPTH;
    @(posedge clk_i); #1;
    alloc_valid_i = 1'b0;
    look(tbb, rdy, v, wt);
    chk(!rdy, "R12", "new entry pending", rdy, 0);
    send(tbb, 32'hBEEF, 0, 0);
    tick(3);

    // mispredicted branch
    do_alloc(2, 0, tb_);
    do_alloc(0, 4, tx);
    do_alloc(1, 0, ty);
    send(tx, 32'h77, 0, 0);
    send(ty, 32'h88, 32'h200, 0);
    send(tb_, 0, 0, 1);
    @(negedge clk_i);
    @(posedge clk_i); #1;
    @(negedge clk_i);
    chk(!commit_valid_o && !st_en_o, "R9", "younger discarded", commit_valid_o, 0);
    @(posedge clk_i); #1;
    look(ty, rdy, v, wt);
    chk(!rdy, "R9", "discarded store gone", rdy, 0);
    do_alloc(0, 5, dummy);
    chk(dummy == (tb_ + 1) % DEPTH, "R9", "claim after branch", dummy, (tb_ + 1) % DEPTH);

    // external flush with claim and result in the same cycle
    do_alloc(0, 6, tq);
    tp = dummy;
    flush_i = 1'b1; alloc_valid_i = 1'b1;
    cdb_valid_i = 1'b1; cdb_tag_i = tp[TW-1:0]; cdb_value_i = 32'h99;
    @(negedge clk_i);
    chk(!alloc_ready_o, "R11", "claim ignored in flush", alloc_ready_o, 0);
    chk(!commit_valid_o, "R10", "no retire in flush", commit_valid_o, 0);
    @(posedge clk_i); #1;
    flush_i = 1'b0; alloc_valid_i = 1'b0; cdb_valid_i = 1'b0;
    q.delete();
    exp_tail = tp;
    do_alloc(0, 8, dummy);
    chk(dummy == tp, "R10", "claim reuses old head", dummy, tp);
    look(tp, rdy, v, wt);
    chk(!rdy, "R11", "result ignored in flush", rdy, 0);
    @(negedge clk_i);
    chk(!commit_valid_o, "R10", "nothing to retire", commit_valid_o, 0);
    @(posedge clk_i); #1;
    send(tp, 32'h42, 0, 0);
    tick(3);
    chk(q.size() == 0, "R10", "drain after flush", q.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule